// File: doc/BRIEF.md
# Serial EEPROM Configuration Loader

After reset this block reads the whole content of a 64-word, 16-bit serial EEPROM over three wires: chip select, serial clock and serial data out. A fourth wire carries data back from the memory. The block drives every wire itself and keeps each level for a programmable number of system clock cycles, so a slow memory can sit beside a fast system clock.

Each word is fetched in its own read transaction. For every word the block sends a start bit and a read command, then shifts in sixteen data bits. All words are added into a 16-bit running sum. When the last word has been read, the block compares the sum with a fixed constant to decide whether the image is genuine. A genuine image supplies the adapter bus ID, a mode byte and a tag code; the tag count is derived from the tag code by shifting. An image that fails the check gives default settings instead. A single done pulse marks the end of loading in both cases.

Top module: `eeprom_cfg_loader`

## Requirements
- R1: Exactly 64 read transactions take place after reset. Transaction k sends 9 bits, MSB first: a start bit of 1, then the command byte 0x80+k.
- R2: Each serial bit has two phases. First the data level is set with the serial clock low for HOLD_CYC cycles, then the serial clock is high for HOLD_CYC cycles. Over one load the serial clock is therefore high for 25*64*HOLD_CYC cycles.
- R3: After the command, 16 data bits are shifted in MSB first. Each bit is sampled in the last cycle of its clock-high phase.
- R4: Chip select is low for at least HOLD_CYC cycles before each transaction. It stays high for the whole transaction, and the serial clock is never high while chip select is low.
- R5: cfgValid is 1 exactly when the 16-bit wrapping sum of all 64 words equals 0x1234.
- R6: With a valid image, byte offsets are little-endian (byte 2k is the low byte of word k). adapterId is byte 0x40 (low byte of word 32) and modeBits is byte 0x41 (high byte of word 32). tagCode is byte 0x43 (high byte of word 33). tagCount is 2 shifted left by tagCode, truncated to TAG_W bits, and activeNeg is modeBits bit 3.
- R7: With an invalid image, adapterId is 7 and modeBits, tagCode, tagCount and activeNeg are all 0.
- R8: cfgDone is a one-cycle pulse given exactly once per load, whether the image is valid or not. From that cycle on, the configuration outputs hold their values.
- R9: During reset, and after a reset that interrupts a load, chip select, serial clock and serial data are low, cfgDone and cfgValid are 0 and adapterId is 7. The load then starts again from word 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset; loading starts when it is released |
| romDo | input | 1 | Serial data returned by the EEPROM |
| romCs | output | 1 | EEPROM chip select, active high |
| romClk | output | 1 | EEPROM serial clock |
| romDi | output | 1 | Serial command data sent to the EEPROM |
| cfgDone | output | 1 | One-cycle pulse when loading has finished |
| cfgValid | output | 1 | Checksum of the image matched |
| adapterId | output | 8 | Adapter bus ID |
| modeBits | output | 8 | Mode option byte |
| tagCode | output | 8 | Tag queue code |
| tagCount | output | TAG_W | Tag count, 2 shifted left by tagCode |
| activeNeg | output | 1 | Active negation enable |

## Verification
The assertions assume that romDo changes only when the serial clock rises. They also assume HOLD_CYC is at least 2, so that a level set at a rising edge has settled before the sample at the end of the high phase. The bench EEPROM model follows these rules: it updates its output only on a rising serial clock while chip select is high, and it clears its bit counter when chip select falls. The bench uses the default HOLD_CYC of 4. Reset is applied only between loads or as a deliberate mid-load abort, and the configuration outputs are judged only after cfgDone.

// File: rtl/eecfg_pkg.sv
package eecfg_pkg;

  localparam int unsigned ROM_WORDS = 64;
  localparam int unsigned WORD_W    = 16;
  localparam int unsigned IDX_W     = $clog2(ROM_WORDS);
  localparam int unsigned CMD_BITS  = 9;
  localparam int unsigned BIT_W     = $clog2(WORD_W);
  localparam int unsigned NUM_FIELDS = 3;

  // byte offsets inside the image; field 0 adapter id, 1 mode, 2 tag code
  localparam logic [7:0] ID_BYTE   = 8'h40;
  localparam logic [7:0] MODE_BYTE = 8'h41;
  localparam logic [7:0] TAG_BYTE  = 8'h43;

  typedef enum logic [2:0] {
    ST_GAP, ST_CMD_LO, ST_CMD_HI, ST_DAT_LO, ST_DAT_HI, ST_FIN, ST_IDLE
  } seqState_t;

  typedef struct packed {
    logic             shiftIn;
    logic             wordEnd;
    logic             finish;
    logic [IDX_W-1:0] wordIdx;
  } seqStrobe_t;

  function automatic logic [7:0] fieldOffset(input int unsigned idx);
    case (idx)
      0:       return ID_BYTE;
      1:       return MODE_BYTE;
      default: return TAG_BYTE;
    endcase
  endfunction

endpackage

// File: rtl/eecfg_ctrl.sv
module eecfg_ctrl
  import eecfg_pkg::*;
#(
  parameter int unsigned HOLD_CYC = 4,
  parameter logic [7:0]  CMD_BASE = 8'h80
) (
  input  logic       clk,
  input  logic       rstN,
  output logic       romCs,
  output logic       romClk,
  output logic       romDi,
  output seqStrobe_t stb
);

  localparam int unsigned HCW = (HOLD_CYC > 1) ? $clog2(HOLD_CYC) : 1;
  localparam logic [HCW-1:0] HOLD_LAST = HCW'(HOLD_CYC - 1);
  localparam logic [IDX_W-1:0] LAST_WORD = IDX_W'(ROM_WORDS - 1);
  localparam logic [BIT_W-1:0] LAST_CMD = BIT_W'(CMD_BITS - 1);
  localparam logic [BIT_W-1:0] LAST_DAT = BIT_W'(WORD_W - 1);

  seqState_t        state, stateNext;
  logic [HCW-1:0]   holdCnt;
  logic [BIT_W-1:0] bitCnt;
  logic [IDX_W-1:0] wordIdx;
  logic             holdEnd;
  logic [CMD_BITS-1:0] cmdBits;

  assign holdEnd = (holdCnt == HOLD_LAST);
  assign cmdBits = {1'b1, CMD_BASE + 8'(wordIdx)};

  always_comb begin
    stateNext = state;
    case (state)
      ST_GAP:    if (holdEnd) stateNext = ST_CMD_LO;
      ST_CMD_LO: if (holdEnd) stateNext = ST_CMD_HI;
      ST_CMD_HI: if (holdEnd) stateNext = (bitCnt == LAST_CMD) ? ST_DAT_LO : ST_CMD_LO;
      ST_DAT_LO: if (holdEnd) stateNext = ST_DAT_HI;
      ST_DAT_HI: begin
        if (holdEnd) begin
          if (bitCnt != LAST_DAT)         stateNext = ST_DAT_LO;
          else if (wordIdx == LAST_WORD)  stateNext = ST_FIN;
          else                            stateNext = ST_GAP;
        end
      end
      ST_FIN:    stateNext = ST_IDLE;
      default:   stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_GAP;
      holdCnt <= '0;
      bitCnt  <= '0;
      wordIdx <= '0;
    end else begin
      state <= stateNext;
      if (stateNext != state) holdCnt <= '0;
      else if (!holdEnd)      holdCnt <= holdCnt + 1'b1;
      if (holdEnd) begin
        if (state == ST_GAP) begin
          bitCnt <= '0;
        end else if (state == ST_CMD_HI) begin
          bitCnt <= (bitCnt == LAST_CMD) ? '0 : bitCnt + 1'b1;
        end else if (state == ST_DAT_HI) begin
          bitCnt <= (bitCnt == LAST_DAT) ? '0 : bitCnt + 1'b1;
          if (bitCnt == LAST_DAT && wordIdx != LAST_WORD) wordIdx <= wordIdx + 1'b1;
        end
      end
    end
  end

  always_comb begin
    romCs  = state inside {ST_CMD_LO, ST_CMD_HI, ST_DAT_LO, ST_DAT_HI};
    romClk = state inside {ST_CMD_HI, ST_DAT_HI};
    romDi  = (state inside {ST_CMD_LO, ST_CMD_HI}) ?
             cmdBits[BIT_W'(CMD_BITS - 1) - bitCnt] : 1'b0;
    stb.shiftIn = (state == ST_DAT_HI) && holdEnd;
    stb.wordEnd = (state == ST_DAT_HI) && holdEnd && (bitCnt == LAST_DAT);
    stb.finish  = (state == ST_FIN);
    stb.wordIdx = wordIdx;
  end

  // R4
  clk_needs_cs_chk: assert property (@(posedge clk) disable iff (!rstN)
    romClk |-> romCs);

  // R4
  cs_rise_clk_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(romCs) |-> !romClk);

  // R1
  start_bit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_CMD_HI && bitCnt == '0) |-> romDi);

  // R2
  hold_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    holdCnt <= HOLD_LAST);

  // R2
  clk_steady_chk: assert property (@(posedge clk) disable iff (!rstN)
    (romClk && !holdEnd) |=> romClk);

endmodule

// File: rtl/eecfg_dp.sv
module eecfg_dp
  import eecfg_pkg::*;
#(
  parameter int unsigned TAG_W     = 16,
  parameter logic [15:0] SUM_CHECK = 16'h1234,
  parameter logic [7:0]  DEF_ID    = 8'd7
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             romDo,
  input  seqStrobe_t       stb,
  output logic             cfgDone,
  output logic             cfgValid,
  output logic [7:0]       adapterId,
  output logic [7:0]       modeBits,
  output logic [7:0]       tagCode,
  output logic [TAG_W-1:0] tagCount,
  output logic             activeNeg
);

  logic [WORD_W-1:0] shiftReg, nextWord, sumAcc;
  logic [7:0]        fieldCap [NUM_FIELDS];
  logic              loaded, sumOk;

  assign nextWord = {shiftReg[WORD_W-2:0], romDo};
  assign sumOk    = (sumAcc == SUM_CHECK);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      sumAcc   <= '0;
    end else begin
      if (stb.shiftIn) shiftReg <= nextWord;
      if (stb.wordEnd) sumAcc   <= sumAcc + nextWord;
    end
  end

  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_field
    localparam logic [7:0] OFFS = fieldOffset(g);
    localparam logic [IDX_W-1:0] WSEL = IDX_W'(OFFS >> 1);
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) fieldCap[g] <= '0;
      else if (stb.wordEnd && stb.wordIdx == WSEL)
        fieldCap[g] <= OFFS[0] ? nextWord[15:8] : nextWord[7:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgDone   <= 1'b0;
      cfgValid  <= 1'b0;
      loaded    <= 1'b0;
      adapterId <= DEF_ID;
      modeBits  <= '0;
      tagCode   <= '0;
      tagCount  <= '0;
      activeNeg <= 1'b0;
    end else begin
      cfgDone <= stb.finish;
      if (stb.finish) begin
        loaded   <= 1'b1;
        cfgValid <= sumOk;
        if (sumOk) begin
          adapterId <= fieldCap[0];
          modeBits  <= fieldCap[1];
          tagCode   <= fieldCap[2];
          tagCount  <= TAG_W'(2) << fieldCap[2];
          activeNeg <= fieldCap[1][3];
        end else begin
          adapterId <= DEF_ID;
          modeBits  <= '0;
          tagCode   <= '0;
          tagCount  <= '0;
          activeNeg <= 1'b0;
        end
      end
    end
  end

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfgDone |=> !cfgDone);

  // R8
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (loaded && !stb.finish) |=> ($stable(adapterId) && $stable(cfgValid) && $stable(tagCount)));

  // R7
  invalid_default_chk: assert property (@(posedge clk) disable iff (!rstN)
    (loaded && !cfgValid) |-> (adapterId == DEF_ID && tagCount == '0 && !activeNeg));

  // R8
  done_once_chk: assert property (@(posedge clk) disable iff (!rstN)
    (loaded && !$past(stb.finish)) |-> !cfgDone);

endmodule

// File: rtl/eeprom_cfg_loader.sv
module eeprom_cfg_loader
  import eecfg_pkg::*;
#(
  parameter int unsigned HOLD_CYC  = 4,
  parameter int unsigned TAG_W     = 16,
  parameter logic [7:0]  CMD_BASE  = 8'h80,
  parameter logic [15:0] SUM_CHECK = 16'h1234
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             romDo,
  output logic             romCs,
  output logic             romClk,
  output logic             romDi,
  output logic             cfgDone,
  output logic             cfgValid,
  output logic [7:0]       adapterId,
  output logic [7:0]       modeBits,
  output logic [7:0]       tagCode,
  output logic [TAG_W-1:0] tagCount,
  output logic             activeNeg
);

  seqStrobe_t stb;

  eecfg_ctrl #(.HOLD_CYC(HOLD_CYC), .CMD_BASE(CMD_BASE)) u_ctrl (
    .clk(clk), .rstN(rstN), .romCs(romCs), .romClk(romClk), .romDi(romDi), .stb(stb)
  );

  eecfg_dp #(.TAG_W(TAG_W), .SUM_CHECK(SUM_CHECK), .DEF_ID(8'd7)) u_dp (
    .clk(clk), .rstN(rstN), .romDo(romDo), .stb(stb),
    .cfgDone(cfgDone), .cfgValid(cfgValid), .adapterId(adapterId),
    .modeBits(modeBits), .tagCode(tagCode), .tagCount(tagCount), .activeNeg(activeNeg)
  );

endmodule

// File: tb/eeprom_cfg_loader_tb.sv
module eeprom_cfg_loader_tb;

  localparam int CLK_PERIOD = 10;
  localparam int HOLD = 4;
  localparam int NVEC = 5;
  localparam int LOAD_LIMIT = 64 * 51 * HOLD + 200;
  // {valid, id, mode, tag, fill}
  localparam logic [32:0] VEC [NVEC] = '{
    {1'b1, 8'h05, 8'h08, 8'h03, 8'hA5},
    {1'b1, 8'h03, 8'h37, 8'h00, 8'h3C},
    {1'b0, 8'h02, 8'hFF, 8'h02, 8'h5A},
    {1'b1, 8'h0F, 8'hF8, 8'h0E, 8'hC3},
    {1'b1, 8'h01, 8'h00, 8'h0F, 8'h96}
  };

  logic clk = 0, rstN = 0, romDo = 0;
  logic romCs, romClk, romDi, cfgDone, cfgValid, activeNeg;
  logic [7:0] adapterId, modeBits, tagCode;
  logic [15:0] tagCount;

  int total = 0, bad = 0;
  logic [15:0] mem [64];

  eeprom_cfg_loader #(.HOLD_CYC(HOLD)) u_dut (
    .clk(clk), .rstN(rstN), .romDo(romDo), .romCs(romCs), .romClk(romClk),
    .romDi(romDi), .cfgDone(cfgDone), .cfgValid(cfgValid), .adapterId(adapterId),
    .modeBits(modeBits), .tagCode(tagCode), .tagCount(tagCount), .activeNeg(activeNeg)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // EEPROM model
  int bitCount = 0, txCount = 0, addrErr = 0;
  logic [8:0] cmdReg = '0;
  logic [15:0] curWord = '0;
  always @(posedge romClk or negedge romCs or negedge rstN) begin
    if (!rstN) begin
      bitCount = 0; txCount = 0; addrErr = 0; romDo = 0;
    end else if (!romCs) begin
      bitCount = 0; romDo = 0;
    end else if (romClk) begin
      bitCount++;
      if (bitCount <= 9) begin
        cmdReg = {cmdReg[7:0], romDi};
        if (bitCount == 9) begin
          if (cmdReg !== {1'b1, 8'h80 + 8'(txCount)}) addrErr++;
          curWord = mem[cmdReg[5:0]];
        end
      end else if (bitCount <= 25) begin
        romDo = curWord[25 - bitCount];
        if (bitCount == 25) txCount++;
      end
    end
  end

  // bus monitors
  int hiCycles = 0, lowRun = 0, minGap = 99999, doneCount = 0;
  logic prevCs = 0;
  always @(negedge clk) begin
    if (!rstN) begin
      hiCycles = 0; lowRun = 0; minGap = 99999; doneCount = 0; prevCs = 0;
    end else begin
      if (romClk) hiCycles++;
      if (cfgDone) doneCount++;
      if (romCs && !prevCs && lowRun < minGap) minGap = lowRun;
      lowRun = romCs ? 0 : lowRun + 1;
      prevCs = romCs;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic buildImage(input logic [32:0] v);
    logic [15:0] s = '0;
    for (int k = 0; k < 63; k++) begin
      mem[k] = {v[7:0] ^ 8'(k), 8'(k * 7) ^ v[7:0]};
      if (k == 32) mem[k] = {v[23:16], v[31:24]};
      if (k == 33) mem[k] = {v[15:8], v[7:0]};
      s = s + mem[k];
    end
    mem[63] = (v[32] ? 16'h1234 : 16'h1235) - s;
  endtask

  task automatic doReset();
    @(negedge clk); rstN = 0;
    repeat (3) @(negedge clk);
    chk("R9 reset cs/clk/di", {29'b0, romCs, romClk, romDi}, 32'h0);
    chk("R9 reset done/valid", {30'b0, cfgDone, cfgValid}, 32'h0);
    chk("R9 reset adapterId", adapterId, 32'h7);
    rstN = 1;
  endtask

  task automatic runLoad(input string name, input logic expValid,
                         input logic [7:0] id, input logic [7:0] md, input logic [7:0] tg);
    int n = 0;
    logic [15:0] expCount;
    doReset();
    while (!cfgDone && n < LOAD_LIMIT) begin @(negedge clk); n++; end
    chk({"R8 done seen ", name}, cfgDone, 1);
    @(negedge clk);
    chk({"R5 valid ", name}, cfgValid, expValid);
    expCount = (tg >= 15) ? 16'h0 : 16'(32'd1 << (tg + 1));
    if (expValid) begin
      chk({"R6 adapterId ", name}, adapterId, id);
      chk({"R6 modeBits ", name}, modeBits, md);
      chk({"R6 tagCode ", name}, tagCode, tg);
      chk({"R6 tagCount ", name}, tagCount, expCount);
      chk({"R6 activeNeg ", name}, activeNeg, md[3]);
    end else begin
      chk({"R7 adapterId ", name}, adapterId, 7);
      chk({"R7 zero fields ", name}, {modeBits, tagCode, tagCount}, 0);
      chk({"R7 activeNeg ", name}, activeNeg, 0);
    end
    chk({"R1 transactions ", name}, txCount, 64);
    chk({"R1 command order ", name}, addrErr, 0);
    chk({"R2 clock high cycles ", name}, hiCycles, 25 * 64 * HOLD);
    chk({"R4 cs gap ", name}, 32'(minGap >= HOLD), 1);
    repeat (20) @(negedge clk);
    chk({"R8 single done ", name}, doneCount, 1);
    chk({"R8 stable id ", name}, adapterId, expValid ? {24'b0, id} : 32'h7);
    chk({"R4 idle cs low ", name}, {romCs, romClk}, 0);
  endtask

  initial begin
    // main table walk (R3 data path checked via decoded fields)
    for (int i = 0; i < NVEC; i++) begin
      buildImage(VEC[i]);
      runLoad($sformatf("vec%0d", i), VEC[i][32], VEC[i][31:24], VEC[i][23:16], VEC[i][15:8]);
    end
    // all-zero image: sum 0 is invalid (R5, R7)
    for (int k = 0; k < 64; k++) mem[k] = '0;
    runLoad("zero image", 1'b0, 8'h0, 8'h0, 8'h0);
    // R9 reset in mid-load, then a complete fresh load
    buildImage(VEC[0]);
    doReset();
    repeat (3000) @(negedge clk);
    rstN = 0;
    @(negedge clk);
    chk("R9 abort cs low", romCs, 0);
    chk("R9 abort done low", cfgDone, 0);
    runLoad("after abort", 1'b1, 8'h05, 8'h08, 8'h03);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule